// File: doc/BRIEF.md
# Agree-Mode Branch Direction Predictor

This block predicts the direction of conditional branches while limiting the harm done when unrelated branches share a pattern counter. A small per-address table of 2-bit saturating counters gives each branch a fairly stable bias direction. A second table of 2-bit counters is shared by many branches. It is indexed by the branch address XOR the global outcome history. Its counters do not record taken or not taken. They record whether the branch tends to follow its own bias. Branches that alias onto the same shared counter are usually each biased their own way, so they all push that counter toward "agree" rather than fighting over it.

A fetch stage presents an address on the lookup side and receives the predicted direction in the same cycle. It also receives the bias bit and the history snapshot used. When the branch resolves, the execute stage returns the address, that history snapshot, that bias bit and the real outcome on the resolve side. The block then trains both tables and shifts the outcome into the global history.

Top module: `agree_predictor`

## Requirements
- R1: After reset every bias counter holds 01 (weak not-taken), every agree counter holds 10 (weak agree) and the global history is all zeros. A lookup at any address then returns lk_base=0, lk_taken=0 and lk_hist=0.
- R2: The bias counter used for an address is the entry selected by address bits [BASE_W-1:0]. lk_base is that counter's upper bit.
- R3: The agree counter used for a lookup is the entry selected by address bits [HIST_W-1:0] XOR the global history. lk_hist shows the global history currently held.
- R4: lk_taken equals lk_base when the selected agree counter's upper bit is 1, and equals the inverse of lk_base when it is 0.
- R5: On a resolve, the agree counter at rs_pc[HIST_W-1:0] XOR rs_hist counts up when rs_taken equals rs_base and counts down otherwise. It stays at 11 when it would go above and at 00 when it would go below.
- R6: On a resolve, the bias counter at rs_pc[BASE_W-1:0] counts up on a taken outcome and down on a not-taken one, saturating at 11 and 00.
- R7: One clock edge after a resolve the history becomes {old_history[HIST_W-2:0], rs_taken}. Without a resolve it keeps its value.
- R8: A lookup and a resolve in the same cycle are allowed. The lookup reflects the tables and history from before that cycle's update, and the update is visible after the next clock edge.
- R9: Training of the agree table uses the returned rs_hist, not the history held at resolve time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_base | output | 1 | Bias direction used for this prediction |
| lk_hist | output | HIST_W | Global history used for this prediction |
| rs_valid | input | 1 | A resolved branch is presented this cycle |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_hist | input | HIST_W | History snapshot returned from its lookup |
| rs_base | input | 1 | Bias bit returned from its lookup |
| rs_taken | input | 1 | Actual outcome (1 = taken) |

## Verification
Lookup and resolve can land in the same cycle, even for the same branch address. The bench provokes this by holding a lookup address while it drives a resolve for that address. It samples the prediction before the edge, where the old counter and history must show. It samples again after the edge, where the retrained bias counter and the shifted history must show. A second case returns a stale history snapshot and judges, by a later lookup that reaches that snapshot's entry, that training went to the entry the snapshot selects.

// File: rtl/agree_predictor.sv
module agree_predictor #(
  parameter int PC_W   = 16,
  parameter int BASE_W = 6,
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic              lk_base,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              rs_valid,
  input  logic [PC_W-1:0]   rs_pc,
  input  logic [HIST_W-1:0] rs_hist,
  input  logic              rs_base,
  input  logic              rs_taken
);
  localparam int BASE_N = 1 << BASE_W;
  localparam int PAT_N  = 1 << HIST_W;

  logic [1:0]        base_tab [BASE_N];
  logic [1:0]        pat_tab  [PAT_N];
  logic [HIST_W-1:0] ghist;

  logic [BASE_W-1:0] b_lidx, b_ridx;
  logic [HIST_W-1:0] p_lidx, p_ridx;
  logic              rs_agree;

  assign b_lidx   = lk_pc[BASE_W-1:0];
  assign p_lidx   = lk_pc[HIST_W-1:0] ^ ghist;
  assign b_ridx   = rs_pc[BASE_W-1:0];
  assign p_ridx   = rs_pc[HIST_W-1:0] ^ rs_hist;
  assign rs_agree = (rs_taken == rs_base);

  assign lk_base  = base_tab[b_lidx][1];
  assign lk_taken = pat_tab[p_lidx][1] ? lk_base : ~lk_base;
  assign lk_hist  = ghist;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BASE_N; i++) base_tab[i] <= 2'b01;
      for (int j = 0; j < PAT_N; j++)  pat_tab[j]  <= 2'b10;
      ghist <= '0;
    end else if (rs_valid) begin
      if (rs_taken) begin
        if (base_tab[b_ridx] != 2'b11) base_tab[b_ridx] <= base_tab[b_ridx] + 2'd1;
      end else begin
        if (base_tab[b_ridx] != 2'b00) base_tab[b_ridx] <= base_tab[b_ridx] - 2'd1;
      end
      if (rs_agree) begin
        if (pat_tab[p_ridx] != 2'b11) pat_tab[p_ridx] <= pat_tab[p_ridx] + 2'd1;
      end else begin
        if (pat_tab[p_ridx] != 2'b00) pat_tab[p_ridx] <= pat_tab[p_ridx] - 2'd1;
      end
      ghist <= {ghist[HIST_W-2:0], rs_taken};
    end
  end

  a_r5_agree_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_agree && pat_tab[p_ridx] != 2'b11)
    |=> pat_tab[$past(p_ridx)] == 2'($past(pat_tab[p_ridx]) + 2'd1));

  a_r5_agree_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_agree && pat_tab[p_ridx] == 2'b00)
    |=> pat_tab[$past(p_ridx)] == 2'b00);

  a_r6_base_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken && base_tab[b_ridx] == 2'b11)
    |=> base_tab[$past(b_ridx)] == 2'b11);

  a_r7_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> lk_hist == {$past(lk_hist[HIST_W-2:0]), $past(rs_taken)});

  a_r7_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(lk_hist));
endmodule

// File: tb/agree_predictor_bench.sv
module agree_predictor_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] lk_pc;
  logic        lk_taken, lk_base;
  logic [5:0]  lk_hist;
  logic        rs_valid;
  logic [15:0] rs_pc;
  logic [5:0]  rs_hist;
  logic        rs_base, rs_taken;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  agree_predictor u_agree_predictor (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_base(lk_base), .lk_hist(lk_hist), .rs_valid(rs_valid),
    .rs_pc(rs_pc), .rs_hist(rs_hist), .rs_base(rs_base), .rs_taken(rs_taken)
  );

  typedef struct packed {
    logic [15:0] pc;
    logic        outcome;
    logic        exp_taken;
    logic        exp_base;
    logic [5:0]  exp_hist;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{16'h0005, 1'b1, 1'b0, 1'b0, 6'h00},
    '{16'h0005, 1'b1, 1'b1, 1'b1, 6'h01},
    '{16'h0005, 1'b1, 1'b1, 1'b1, 6'h03},
    '{16'h0005, 1'b0, 1'b1, 1'b1, 6'h07},
    '{16'h0005, 1'b0, 1'b1, 1'b1, 6'h0E},
    '{16'h0005, 1'b0, 1'b0, 1'b0, 6'h1C},
    '{16'h0021, 1'b0, 1'b0, 1'b0, 6'h38},
    '{16'h0005, 1'b1, 1'b0, 1'b0, 6'h30},
    '{16'h0004, 1'b1, 1'b0, 1'b0, 6'h21},
    '{16'h0005, 1'b0, 1'b0, 1'b0, 6'h03},
    '{16'h0003, 1'b1, 1'b1, 1'b0, 6'h06},
    '{16'h0008, 1'b1, 1'b1, 1'b0, 6'h0D}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic look(input string req, input logic t, input logic b, input logic [5:0] h);
    chk({req, " taken"}, {7'd0, lk_taken}, {7'd0, t});
    chk({req, " base"},  {7'd0, lk_base},  {7'd0, b});
    chk({req, " hist"},  {2'd0, lk_hist},  {2'd0, h});
  endtask

  task automatic resolve(input logic [15:0] pc, input logic [5:0] h, input logic b, input logic t);
    rs_pc = pc; rs_hist = h; rs_base = b; rs_taken = t; rs_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rs_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; rs_valid = 1'b0; lk_pc = 16'h0005;
    rs_pc = '0; rs_hist = '0; rs_base = 1'b0; rs_taken = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 look("R1 reset", 1'b0, 1'b0, 6'h00);
    lk_pc = 16'h003F;
    #1 look("R1 reset other", 1'b0, 1'b0, 6'h00);

    // R2 R3 R4 R5 R6 R7: walked training sequence
    for (int k = 0; k < 12; k++) begin
      lk_pc = VEC[k].pc;
      #1 look($sformatf("R4 vec%0d", k), VEC[k].exp_taken, VEC[k].exp_base, VEC[k].exp_hist);
      resolve(VEC[k].pc, lk_hist, lk_base, VEC[k].outcome);
    end

    // R7: history holds while idle
    repeat (3) @(negedge clk);
    #1 chk("R7 hold", {2'd0, lk_hist}, 8'h1B);

    // R8: lookup and resolve of the same address in one cycle
    lk_pc = 16'h0008;
    rs_pc = 16'h0008; rs_hist = 6'h1B; rs_base = 1'b1; rs_taken = 1'b0; rs_valid = 1'b1;
    #1 look("R8 pre-edge", 1'b1, 1'b1, 6'h1B);
    @(posedge clk);
    @(negedge clk);
    rs_valid = 1'b0;
    #1 look("R8 post-edge", 1'b0, 1'b0, 6'h36);

    // R9: stale history snapshot selects the trained agree entry
    resolve(16'h0000, 6'h00, 1'b1, 1'b0);
    lk_pc = 16'h002C;
    #1 look("R9 stale hist", 1'b1, 1'b0, 6'h2C);

    // R1: reset in mid-run restores initial state
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    lk_pc = 16'h0005;
    #1 look("R1 re-reset", 1'b0, 1'b0, 6'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule